// File: doc/BRIEF.md
# ATA Command Issue Sequencer

The sequencer sits on the host side of an ATA task-file port. It takes a single command request and turns it into the ordered series of byte writes that loads the task-file registers and then starts the command. A request carries a 48-bit logical block address, a 16-bit sector count, a 16-bit feature value, an operation selector, an extended-addressing flag and a device-select bit.

The block captures the request when it is idle. It then presents one register write at a time on `wr_en`/`wr_addr`/`wr_data` and holds each write until the port answers with `wr_ready`. It selects the command opcode from the operation and the addressing mode. In 28-bit mode it folds the top address nibble into the device byte. In 48-bit mode it loads each paired register high byte first. The command register write always comes last, and `done` pulses for one cycle once that write is accepted. The data phase, interrupts and status polling are handled elsewhere.

Top module: `tf_issue_seq`

## Requirements
- R1: While reset is active and on the first clock after it, `wr_en` and `done` are 0.
- R2: A request is captured only when no sequence is running (`done` may be high in that cycle). The first write (address 1) appears on the clock after capture. `req_valid` and the request fields are ignored while a sequence is running.
- R3: While `wr_en` is 1 and `wr_ready` is 0, `wr_en`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R4: With `req_ext`=0 the sequence has seven writes, to addresses 1,2,3,4,5,6,7. The data for addresses 1 to 5 is feature[7:0], count[7:0], lba[7:0], lba[15:8] and lba[23:16].
- R5: With `req_ext`=1 the sequence has twelve writes, to addresses 1,1,2,2,3,3,4,4,5,5,6,7. Each paired address takes its high byte first: feature[15:8] then [7:0]; count[15:8] then [7:0]; lba[31:24] then [7:0]; lba[39:32] then [15:8]; lba[47:40] then [23:16].
- R6: With `req_ext`=0 the device byte (address 6) is 0xE0 | (req_dev<<4) | lba[27:24].
- R7: With `req_ext`=1 the device byte is 0xE0 | (req_dev<<4), and its low nibble is zero.
- R8: The command byte (address 7) is selected by `req_op`: 00 gives 0x20, or 0x24 when extended. 01 gives 0x30, or 0x34 when extended. 1x gives 0xEC in either mode.
- R9: The command write is the last write of a sequence. `done` is 1 for exactly the one cycle after the command write is accepted, and `wr_en` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_lba | input | 48 | Logical block address |
| req_count | input | 16 | Sector count |
| req_feature | input | 16 | Feature register value |
| req_op | input | 2 | 00 read, 01 write, 1x identify |
| req_ext | input | 1 | 1 selects 48-bit addressing |
| req_dev | input | 1 | Device select (1 = device 1) |
| wr_en | output | 1 | Register write request |
| wr_addr | output | 3 | Task-file register address |
| wr_data | output | 8 | Register write data |
| wr_ready | input | 1 | Port accepts the current write |
| done | output | 1 | One-cycle pulse after the command write |

## Verification
Embedded properties check on every cycle that a stalled write stays stable, that a sequence starts at the feature register, that register addresses never move backwards, that the command write ends the sequence with a lone `done` pulse, and that the extended device byte has a clear low nibble. Only the bench's scenarios can show the exact byte values. These include the high-before-low pairing, the nibble folded into the device byte, the opcode per operation and mode, and the fact that requests raised mid-sequence leave the write stream untouched. The bench compares each write against a queue built from the requirements while `wr_ready` stalls at random.

// File: rtl/tf_issue_pkg.sv
package tf_issue_pkg;
    localparam int LBA_W   = 48;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int BYTE_W  = 8;
    localparam int STEP_W  = 4;
    localparam int PAIRS   = 5;
    localparam int LAST_NARROW = PAIRS + 1;
    localparam int LAST_WIDE   = 2 * PAIRS + 1;

    localparam logic [ADDR_W-1:0] REG_FEATURE = 3'd1;
    localparam logic [ADDR_W-1:0] REG_DEVICE  = 3'd6;
    localparam logic [ADDR_W-1:0] REG_COMMAND = 3'd7;

    localparam logic [BYTE_W-1:0] DEV_BASE    = 8'hE0;
    localparam logic [BYTE_W-1:0] OPC_READ    = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_WRITE   = 8'h30;
    localparam logic [BYTE_W-1:0] OPC_IDENT   = 8'hEC;
    localparam logic [BYTE_W-1:0] OPC_EXT_ADD = 8'h04;

    typedef struct packed {
        logic [LBA_W-1:0]  lba;
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] feature;
        logic [1:0]        op;
        logic              ext;
        logic              dev;
    } tf_req_t;
endpackage

// File: rtl/tf_cmd_encode.sv
module tf_cmd_encode
    import tf_issue_pkg::*;
(
    input  logic [1:0]        op,
    input  logic              ext,
    input  logic              dev,
    input  logic [3:0]        lba_top,
    output logic [BYTE_W-1:0] opcode,
    output logic [BYTE_W-1:0] dev_byte
);
    always_comb begin
        if (op[1]) begin
            opcode = OPC_IDENT;
        end else begin
            opcode = op[0] ? OPC_WRITE : OPC_READ;
            if (ext) begin
                opcode = opcode | OPC_EXT_ADD;
            end
        end
        dev_byte = DEV_BASE | {3'b000, dev, 4'b0000};
        if (!ext) begin
            dev_byte[3:0] = lba_top;
        end
    end
endmodule

// File: rtl/tf_step_mux.sv
module tf_step_mux
    import tf_issue_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic              ext,
    input  logic [LBA_W-1:0]  lba,
    input  logic [WORD_W-1:0] count,
    input  logic [WORD_W-1:0] feature,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] dev_byte,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] data,
    output logic              last
);
    logic [WORD_W-1:0] pair_word [PAIRS];

    assign pair_word[0] = feature;
    assign pair_word[1] = count;

    genvar g;
    generate
        for (g = 0; g < PAIRS - 2; g++) begin : g_lba_pair
            assign pair_word[g+2] = {lba[24 + 8*g +: 8], lba[8*g +: 8]};
        end
    endgenerate

    logic [2:0] pair_idx;
    logic       hi_sel;
    logic       is_dev;
    logic       is_cmd;

    always_comb begin
        if (ext) begin
            pair_idx = step[3:1];
            hi_sel   = !step[0];
            is_dev   = (step == STEP_W'(LAST_WIDE - 1));
            is_cmd   = (step == STEP_W'(LAST_WIDE));
        end else begin
            pair_idx = step[2:0];
            hi_sel   = 1'b0;
            is_dev   = (step == STEP_W'(LAST_NARROW - 1));
            is_cmd   = (step == STEP_W'(LAST_NARROW));
        end
        last = is_cmd;
        if (is_cmd) begin
            addr = REG_COMMAND;
            data = opcode;
        end else if (is_dev) begin
            addr = REG_DEVICE;
            data = dev_byte;
        end else if (pair_idx < 3'(PAIRS)) begin
            addr = REG_FEATURE + pair_idx;
            data = hi_sel ? pair_word[pair_idx][15:8] : pair_word[pair_idx][7:0];
        end else begin
            addr = REG_FEATURE;
            data = '0;
        end
    end
endmodule

// File: rtl/tf_issue_seq.sv
module tf_issue_seq
    import tf_issue_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [47:0]       req_lba,
    input  logic [15:0]       req_count,
    input  logic [15:0]       req_feature,
    input  logic [1:0]        req_op,
    input  logic              req_ext,
    input  logic              req_dev,
    output logic              wr_en,
    output logic [2:0]        wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ready,
    output logic              done
);
    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        tf_req_t           req;
        logic              done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [BYTE_W-1:0] opcode;
    logic [BYTE_W-1:0] dev_byte;
    logic              step_last;

    tf_cmd_encode u_enc (
        .op       (s_q.req.op),
        .ext      (s_q.req.ext),
        .dev      (s_q.req.dev),
        .lba_top  (s_q.req.lba[27:24]),
        .opcode   (opcode),
        .dev_byte (dev_byte)
    );

    tf_step_mux u_mux (
        .step     (s_q.step),
        .ext      (s_q.req.ext),
        .lba      (s_q.req.lba),
        .count    (s_q.req.count),
        .feature  (s_q.req.feature),
        .opcode   (opcode),
        .dev_byte (dev_byte),
        .addr     (wr_addr),
        .data     (wr_data),
        .last     (step_last)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (req_valid) begin
                s_d.busy = 1'b1;
                s_d.step = '0;
                s_d.req  = '{lba: req_lba, count: req_count, feature: req_feature,
                             op: req_op, ext: req_ext, dev: req_dev};
            end
        end else if (wr_ready) begin
            if (step_last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.step = s_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en = s_q.busy;
    assign done  = s_q.done;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_data))); // R3
    AST_START_FEATURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_addr == REG_FEATURE)); // R2
    AST_ADDR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && wr_addr != REG_COMMAND) |=> (wr_en && wr_addr >= $past(wr_addr))); // R4
    AST_CMD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && wr_addr == REG_COMMAND) |=> (done && !wr_en)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_WIDE_DEV_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_DEVICE && s_q.req.ext) |-> (wr_data[3:0] == 4'h0)); // R7
endmodule

// File: tb/tf_issue_seq_tb_top.sv
module tf_issue_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_lba = '0;
    logic [15:0] req_count = '0;
    logic [15:0] req_feature = '0;
    logic [1:0]  req_op = '0;
    logic        req_ext = 1'b0;
    logic        req_dev = 1'b0;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        wr_ready = 1'b0;
    logic        done;

    always #2 clk = ~clk;

    tf_issue_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lba(req_lba),
        .req_count(req_count), .req_feature(req_feature), .req_op(req_op),
        .req_ext(req_ext), .req_dev(req_dev), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .done(done)
    );

    int checks = 0;
    int errors = 0;
    logic [10:0] exp_q[$];
    logic done_exp = 1'b0;
    logic prev_stall = 1'b0;
    logic [2:0] prev_addr = '0;
    logic [7:0] prev_data = '0;
    logic start_exp = 1'b0;
    logic cur_ext = 1'b0;
    int ready_pct = 100;
    logic monitor_on = 1'b0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_opcode(input logic [1:0] op, input logic ext);
        if (op[1]) return 8'hEC;
        return (op[0] ? 8'h30 : 8'h20) + (ext ? 8'h04 : 8'h00);
    endfunction

    task automatic load_model();
        logic [7:0] dv;
        dv = 8'hE0 | {3'b0, req_dev, 4'b0};
        cur_ext = req_ext;
        if (req_ext) begin
            exp_q.push_back({3'd1, req_feature[15:8]});
            exp_q.push_back({3'd1, req_feature[7:0]});
            exp_q.push_back({3'd2, req_count[15:8]});
            exp_q.push_back({3'd2, req_count[7:0]});
            exp_q.push_back({3'd3, req_lba[31:24]});
            exp_q.push_back({3'd3, req_lba[7:0]});
            exp_q.push_back({3'd4, req_lba[39:32]});
            exp_q.push_back({3'd4, req_lba[15:8]});
            exp_q.push_back({3'd5, req_lba[47:40]});
            exp_q.push_back({3'd5, req_lba[23:16]});
        end else begin
            exp_q.push_back({3'd1, req_feature[7:0]});
            exp_q.push_back({3'd2, req_count[7:0]});
            exp_q.push_back({3'd3, req_lba[7:0]});
            exp_q.push_back({3'd4, req_lba[15:8]});
            exp_q.push_back({3'd5, req_lba[23:16]});
            dv[3:0] = req_lba[27:24];
        end
        exp_q.push_back({3'd6, dv});
        exp_q.push_back({3'd7, exp_opcode(req_op, req_ext)});
    endtask

    // wr_ready changes just after each rising edge
    always @(posedge clk) begin
        #1 wr_ready <= ($urandom_range(99) < ready_pct);
    end

    // reference model compared on every falling edge
    always @(negedge clk) begin
        if (monitor_on) begin
            string tag;
            logic was_empty;
            check(wr_en == (exp_q.size() != 0), "R2 wr_en vs model", wr_en, exp_q.size() != 0);
            check(done == done_exp, "R9 done pulse", done, done_exp);
            if (done) check(!wr_en, "R9 wr_en low in done cycle", wr_en, 0);
            if (start_exp) check(wr_en && wr_addr == 3'd1, "R2 first write after capture", wr_addr, 1);
            if (prev_stall)
                check(wr_en && wr_addr == prev_addr && wr_data == prev_data,
                      "R3 stalled write held", {wr_addr, wr_data}, {prev_addr, prev_data});
            if (wr_en && exp_q.size() != 0) begin
                if (exp_q[0][10:8] == 3'd7) tag = "R8 command byte";
                else if (exp_q[0][10:8] == 3'd6) tag = cur_ext ? "R7 device byte" : "R6 device byte";
                else tag = cur_ext ? "R5 wide byte order" : "R4 narrow byte order";
                check({wr_addr, wr_data} == exp_q[0], tag, {wr_addr, wr_data}, exp_q[0]);
            end
            was_empty  = (exp_q.size() == 0);
            prev_stall = wr_en && !wr_ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
            done_exp   = 1'b0;
            start_exp  = 1'b0;
            if (wr_en && wr_ready && exp_q.size() != 0) begin
                void'(exp_q.pop_front());
                done_exp = (exp_q.size() == 0);
            end
            if (was_empty && req_valid) begin
                load_model();
                start_exp = 1'b1;
            end
        end
    end

    task automatic issue(input logic [47:0] lba, input logic [15:0] cnt, input logic [15:0] ft,
                         input logic [1:0] op, input logic ext, input logic dev);
        @(posedge clk); #1;
        req_valid = 1'b1; req_lba = lba; req_count = cnt; req_feature = ft;
        req_op = op; req_ext = ext; req_dev = dev;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!wr_en && !done, "R1 outputs during reset", {wr_en, done}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en && !done, "R1 outputs after reset", {wr_en, done}, 0);
        monitor_on = 1'b1;

        // R4 R6 R8: narrow read, device 0
        issue(48'h0000_0A12_3456, 16'h0008, 16'h0000, 2'b00, 1'b0, 1'b0); wait_idle();
        // R4 R6 R8: narrow write, device 1
        issue(48'hFFFF_F5AB_CDEF, 16'h1203, 16'h00C1, 2'b01, 1'b0, 1'b1); wait_idle();
        // R8: identify narrow
        issue(48'h0, 16'h0001, 16'h0000, 2'b10, 1'b0, 1'b1); wait_idle();
        // R5 R7 R8: wide read, example address
        issue(48'h1234_56AB_CDEF, 16'hA55A, 16'h3C4D, 2'b00, 1'b1, 1'b0); wait_idle();
        // R5 R7 R8: wide write, device 1
        issue(48'hFEDC_BA98_7654, 16'h0100, 16'h8001, 2'b01, 1'b1, 1'b1); wait_idle();
        // R8: identify with op 11 in wide mode
        issue(48'h0F0F_0F0F_0F0F, 16'h0000, 16'hFFFF, 2'b11, 1'b1, 1'b0); wait_idle();

        // R3: heavy stalls
        ready_pct = 30;
        issue(48'h8000_0000_0001, 16'hFFFF, 16'h7F80, 2'b01, 1'b1, 1'b1); wait_idle();
        issue(48'h0000_0FFF_FFFF, 16'h00FF, 16'h0055, 2'b00, 1'b0, 1'b1); wait_idle();

        // R2: requests raised mid-sequence are ignored
        ready_pct = 50;
        issue(48'h1111_2222_3333, 16'h4444, 16'h5555, 2'b00, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #1 req_valid = 1'b1; req_lba = 48'hDEAD_BEEF_0000; req_op = 2'b10; req_ext = 1'b0;
        repeat (4) @(posedge clk);
        #1 req_valid = 1'b0;
        wait_idle();

        // R2 R9: request held high, new capture in the done cycle
        ready_pct = 100;
        @(posedge clk); #1;
        req_valid = 1'b1; req_lba = 48'h0000_0123_4567; req_count = 16'h0002;
        req_feature = 16'h0000; req_op = 2'b01; req_ext = 1'b0; req_dev = 1'b0;
        repeat (20) @(posedge clk);
        #1 req_valid = 1'b0;
        wait_idle();

        // random mix
        ready_pct = 60;
        for (int i = 0; i < 60; i++) begin
            issue({$urandom, $urandom}, 16'($urandom), 16'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom));
            wait_idle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule